// File: doc/BRIEF.md
# Double-Buffered Clock Register Bank

This block is a byte-wide register file mapped into a 2K x 8 address space. The highest eight byte addresses hold a control byte and seven timekeeping registers. Every lower address falls through to a plain synchronous RAM. A separate calendar counter block runs the live time and feeds it in on `live_time`. This block keeps a user-visible copy of those counters, and that copy is the only thing the bus reads or writes.

With no hold bit set, the user copy tracks the live counters on every cycle. Software sets the read hold to freeze the copy so it can read a coherent snapshot. Software sets the write hold to freeze the copy and then overwrite it. Clearing the write hold sends a one-cycle `commit` pulse with the loaded values, and the counter block loads them. On that pulse the counter block also restarts its sub-second prescaler, so the first increment after loading comes one full second later.

Two control bits sit inside the time registers. An oscillator-stop bit in the seconds byte gates the counter block through `osc_run`. A frequency-test bit in the day byte makes the seconds LSB toggle at each 512 Hz strobe while the oscillator runs.

Top module: `rtc_regbank`

## Requirements
- R1: Byte addresses 0x7F8..0x7FF select, in this order, control, seconds, minutes, hour, day, date, month and year. Each read returns its data in `rdata` one cycle after the read is presented. `live_time` and `commit_time` pack seconds in bits 7:0, minutes in 15:8, hour in 23:16, day in 31:24, date in 39:32, month in 47:40 and year in 55:48.
- R2: While no hold bit is set, a read of a time register returns the live counter byte. The refresh takes effect on the clock edge after the live value changes.
- R3: Control bit 6 is the read hold. While it is 1, all seven time registers keep the values captured on the edge that set it, and they do so even when `live_time` changes.
- R4: Clearing the read hold refreshes all seven time registers from `live_time` together, on the first edge after the clearing write.
- R5: Control bit 7 is the write hold. A write to a time field is stored only while the write hold is 1. Otherwise the write is ignored and the register keeps showing the held or live value.
- R6: A control write that changes the write hold from 1 to 0 raises `commit` for exactly one cycle, and `commit_time` carries the loaded values during that cycle. The user copy is not refreshed during the commit cycle. No other write produces `commit`.
- R7: Seconds bit 7 is the oscillator stop. It can be written at any time, it reads back, and `osc_run` is its inverse from the edge after the write.
- R8: Day bit 6 is the frequency test. While it is set, a toggle flips on each `tick_512` strobe that arrives with the oscillator running, and seconds reads return bit 0 XOR the toggle. Clearing the bit clears the toggle.
- R9: Unused bits are stored as 0 and read as 0. The field masks are: seconds 0x7F, minutes 0x7F, hour 0x3F, day 0x07, date 0x3F, month 0x1F, year 0xFF. The control byte reads as {write hold, read hold, 000000}.
- R10: Addresses below 0x7F8 read and write the RAM with one-cycle read latency. These accesses leave every clock register and control bit unchanged.
- R11: After reset both hold bits, the oscillator stop and the frequency test read 0, `osc_run` is 1 and `commit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after the read |
| live_time | input | 56 | Live counter bytes from the counter block |
| tick_512 | input | 1 | One-cycle 512 Hz strobe from the timebase |
| osc_run | output | 1 | Counter advance enable for the counter block |
| commit | output | 1 | One-cycle pulse: load counters and restart the prescaler |
| commit_time | output | 56 | Values to load, same packing as live_time |

## Verification
Two events can fall in the same cycle: the write-hold commit and the refresh of the user copy. One control write clears both hold bits at once, so the release of the read hold asks for a refresh on the same edge where the commit pulse goes out. The bench behaves like a counter block that loads one cycle late: it keeps the old live value visible during the commit cycle and then reads back immediately. A design that refreshed during the pulse would return the stale counters in place of the loaded values. A second coincidence is a frequency-test strobe that arrives while the oscillator-stop bit is set; the bench checks that such a strobe leaves the seconds LSB alone.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int NTIME  = 7;
  localparam int TIME_W = NTIME * BYTE_W;

  localparam logic [2:0] IDX_CTL  = 3'd0;
  localparam logic [2:0] IDX_SEC  = 3'd1;
  localparam logic [2:0] IDX_DAY  = 3'd4;

  localparam int CTL_WHOLD = 7;
  localparam int CTL_RHOLD = 6;
  localparam int SEC_STOP  = 7;
  localparam int DAY_FTEST = 6;

  // bits of each time register that hold counter data
  function automatic logic [BYTE_W-1:0] time_mask(input logic [2:0] idx);
    case (idx)
      3'd1:    time_mask = 8'h7F;
      3'd2:    time_mask = 8'h7F;
      3'd3:    time_mask = 8'h3F;
      3'd4:    time_mask = 8'h07;
      3'd5:    time_mask = 8'h3F;
      3'd6:    time_mask = 8'h1F;
      3'd7:    time_mask = 8'hFF;
      default: time_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              sec_we,
  input  logic              day_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick_512,
  output logic              whold,
  output logic              rhold,
  output logic              osc_stop,
  output logic              ftest,
  output logic              ft_tog,
  output logic              commit,
  output logic              refresh_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      whold    <= 1'b0;
      rhold    <= 1'b0;
      osc_stop <= 1'b0;
      ftest    <= 1'b0;
      ft_tog   <= 1'b0;
      commit   <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (ctl_we) begin
        whold  <= wdata[CTL_WHOLD];
        rhold  <= wdata[CTL_RHOLD];
        commit <= whold & ~wdata[CTL_WHOLD];
      end
      if (sec_we) osc_stop <= wdata[SEC_STOP];
      if (day_we) ftest    <= wdata[DAY_FTEST];
      if (!ftest)                       ft_tog <= 1'b0;
      else if (tick_512 && !osc_stop)  ft_tog <= ~ft_tog;
    end
  end

  // no refresh while frozen, nor in the cycle the counters are loading
  assign refresh_en = ~(whold | rhold | commit);
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              refresh_en,
  input  logic              fld_we,
  input  logic [2:0]        fld_idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [TIME_W-1:0] live_time,
  output logic [TIME_W-1:0] user_time
);
  for (genvar g = 0; g < NTIME; g++) begin : g_reg
    localparam logic [2:0]        IDX  = 3'(g + 1);
    localparam logic [BYTE_W-1:0] MASK = time_mask(IDX);

    always_ff @(posedge clk) begin
      if (rst)
        user_time[g*BYTE_W +: BYTE_W] <= '0;
      else if (fld_we && fld_idx == IDX)
        user_time[g*BYTE_W +: BYTE_W] <= wdata & MASK;
      else if (refresh_en)
        user_time[g*BYTE_W +: BYTE_W] <= live_time[g*BYTE_W +: BYTE_W] & MASK;
    end
  end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [TIME_W-1:0] live_time,
  input  logic              tick_512,
  output logic              osc_run,
  output logic              commit,
  output logic [TIME_W-1:0] commit_time
);
  localparam logic [AW-1:0] BASE = AW'((1 << AW) - 8);

  logic              hit, hit_q;
  logic [2:0]        idx;
  logic              wr_clk;
  logic              whold, rhold, osc_stop, ftest, ft_tog, refresh_en;
  logic [TIME_W-1:0] user_time;
  logic [BYTE_W-1:0] reg_q, ram_q;

  assign hit    = (addr >= BASE);
  assign idx    = addr[2:0];
  assign wr_clk = sel & wr & hit;

  rtc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctl_we     (wr_clk && idx == IDX_CTL),
    .sec_we     (wr_clk && idx == IDX_SEC),
    .day_we     (wr_clk && idx == IDX_DAY),
    .wdata      (wdata),
    .tick_512   (tick_512),
    .whold      (whold),
    .rhold      (rhold),
    .osc_stop   (osc_stop),
    .ftest      (ftest),
    .ft_tog     (ft_tog),
    .commit     (commit),
    .refresh_en (refresh_en)
  );

  rtc_shadow u_shadow (
    .clk        (clk),
    .rst        (rst),
    .refresh_en (refresh_en),
    .fld_we     (wr_clk && whold && idx != IDX_CTL),
    .fld_idx    (idx),
    .wdata      (wdata),
    .live_time  (live_time),
    .user_time  (user_time)
  );

  rtc_ram #(.AW(AW), .DW(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (sel & wr & ~hit),
    .addr  (addr),
    .wdata (wdata),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      reg_q <= '0;
    end else begin
      hit_q <= hit;
      case (idx)
        IDX_CTL: reg_q <= {whold, rhold, 6'b0};
        IDX_SEC: reg_q <= {osc_stop, user_time[6:1], user_time[0] ^ ft_tog};
        IDX_DAY: reg_q <= {1'b0, ftest, 3'b0, user_time[3*BYTE_W +: 3]};
        default: reg_q <= user_time[(idx-3'd1)*BYTE_W +: BYTE_W];
      endcase
    end
  end

  assign rdata       = hit_q ? reg_q : ram_q;
  assign osc_run     = ~osc_stop;
  assign commit_time = user_time;
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          sel,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic          commit,
  input logic          osc_run,
  input logic          whold,
  input logic          rhold,
  input logic [55:0]   user_time
);
  localparam logic [AW-1:0] BASE_A = AW'((1 << AW) - 8);
  localparam logic [AW-1:0] SEC_A  = AW'((1 << AW) - 7);

  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R6
  commit_from_whold_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> (!whold && $past(whold)));

  // R7
  osc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sel && wr && addr == SEC_A) |-> (osc_run == !$past(wdata[7])));

  // R3
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(whold || rhold) && !$past(sel && wr)) |-> $stable(user_time));

  // R10
  ram_isolation_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sel && wr && addr < BASE_A) |-> ($stable(whold) && $stable(rhold) && !commit));
endmodule

bind rtc_regbank rtc_regbank_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel       (sel),
  .wr        (wr),
  .addr      (addr),
  .wdata     (wdata),
  .commit    (commit),
  .osc_run   (osc_run),
  .whold     (whold),
  .rhold     (rhold),
  .user_time (user_time)
);

// File: tb/sim_rtc_regbank.sv
module sim_rtc_regbank;
  localparam int AW = 11;
  localparam logic [10:0] A_CTL = 11'h7F8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wr  = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [55:0] live_v = '0;
  logic        tick_512 = 1'b0;
  logic        osc_run, commit;
  logic [55:0] commit_time;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rtc_regbank #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .live_time(live_v), .tick_512(tick_512),
    .osc_run(osc_run), .commit(commit), .commit_time(commit_time)
  );

  function automatic logic [7:0] fmask(input int i);
    case (i)
      1: return 8'h7F;  2: return 8'h7F;  3: return 8'h3F;  4: return 8'h07;
      5: return 8'h3F;  6: return 8'h1F;  7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] lbyte(input logic [55:0] t, input int i);
    return t[(i-1)*8 +: 8] & fmask(i);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_512 = 1'b1;
    @(negedge clk); tick_512 = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  logic [7:0]  ref_mem [2048];
  logic [10:0] ram_a [32];

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0]  d;
    logic [55:0] snap, loaded, cap;
    int          i;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 osc_run", osc_run, 1);
    chk("R11 commit", commit, 0);
    bus_rd(A_CTL, d);       chk("R11 ctl", d, 8'h00);
    bus_rd(A_CTL + 4, d);   chk("R11 day ft", d, 8'h00);

    // R1 R2 R9: random live values follow through, masked
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      live_v = {$urandom(), $urandom()};
      i = 1 + int'($urandom_range(6));
      bus_rd(A_CTL + 11'(i), d);
      chk($sformatf("R2 R9 R1 reg%0d", i), d, lbyte(live_v, i));
    end

    // R3 read hold freezes snapshot
    live_v = 56'h12_11_25_03_17_42_30;
    bus_wr(A_CTL, 8'h40);
    snap = live_v;
    live_v = 56'h12_11_25_03_17_42_31;
    repeat (3) @(negedge clk);
    bus_rd(A_CTL, d);       chk("R3 ctl readback", d, 8'h40);
    bus_rd(A_CTL + 1, d);   chk("R3 sec frozen", d, lbyte(snap, 1));
    bus_rd(A_CTL + 7, d);   chk("R3 year frozen", d, lbyte(snap, 7));
    // R5 write ignored without write hold
    bus_wr(A_CTL + 2, 8'h05);
    bus_rd(A_CTL + 2, d);   chk("R5 min ignored", d, lbyte(snap, 2));
    // R4 release refreshes all at once
    bus_wr(A_CTL, 8'h00);
    chk("R6 no commit on rhold clear", commit, 0);
    bus_rd(A_CTL + 1, d);   chk("R4 sec refreshed", d, 8'h31);
    bus_rd(A_CTL + 2, d);   chk("R4 min refreshed", d, 8'h42);

    // R5 R9 write hold, masks
    bus_wr(A_CTL, 8'hFF);
    bus_rd(A_CTL, d);       chk("R9 ctl unused", d, 8'hC0);
    bus_wr(A_CTL + 3, 8'hFF);
    bus_rd(A_CTL + 3, d);   chk("R9 hour mask", d, 8'h3F);
    bus_wr(A_CTL + 6, 8'hFF);
    bus_rd(A_CTL + 6, d);   chk("R9 month mask", d, 8'h1F);
    bus_wr(A_CTL + 4, 8'hFF);
    bus_rd(A_CTL + 4, d);   chk("R9 day mask ft", d, 8'h47);
    bus_wr(A_CTL + 1, 8'h45);
    bus_wr(A_CTL + 2, 8'h59);
    bus_wr(A_CTL + 3, 8'h23);
    bus_wr(A_CTL + 4, 8'h03);
    bus_wr(A_CTL + 5, 8'h31);
    bus_wr(A_CTL + 6, 8'h12);
    bus_wr(A_CTL + 7, 8'h99);
    loaded = 56'h99_12_31_03_23_59_45;
    live_v = 56'h01_01_01_01_00_00_07;
    bus_rd(A_CTL + 2, d);   chk("R5 min loaded", d, 8'h59);

    // R6 commit with both holds clearing at once
    bus_wr(A_CTL, 8'h00);
    chk("R6 commit high", commit, 1);
    chk("R6 commit_time", commit_time, loaded);
    cap = commit_time;
    @(negedge clk);
    chk("R6 commit one cycle", commit, 0);
    live_v = cap;
    sel = 1'b1; wr = 1'b0; addr = A_CTL + 1;
    @(negedge clk); sel = 1'b0; d = rdata;
    chk("R6 no stale refresh", d, 8'h45);
    bus_rd(A_CTL + 7, d);   chk("R6 year after load", d, 8'h99);

    // R7 oscillator stop
    live_v = 56'h01_01_01_01_00_00_10;
    bus_wr(A_CTL + 1, 8'h80);
    chk("R7 osc_run low", osc_run, 0);
    bus_rd(A_CTL + 1, d);   chk("R7 stop readback", d, 8'h90);

    // R8 frequency test
    bus_wr(A_CTL + 1, 8'h00);
    chk("R7 osc_run high", osc_run, 1);
    bus_wr(A_CTL + 4, 8'h40);
    bus_rd(A_CTL + 4, d);   chk("R8 ft readback", d, 8'h41);
    bus_rd(A_CTL + 1, d);   chk("R8 no tick yet", d, 8'h10);
    pulse_tick();
    bus_rd(A_CTL + 1, d);   chk("R8 toggled", d, 8'h11);
    pulse_tick();
    bus_rd(A_CTL + 1, d);   chk("R8 toggled back", d, 8'h10);
    bus_wr(A_CTL + 1, 8'h80);
    pulse_tick();
    bus_rd(A_CTL + 1, d);   chk("R8 stopped no toggle", d, 8'h90);
    bus_wr(A_CTL + 1, 8'h00);
    pulse_tick();
    bus_wr(A_CTL + 4, 8'h00);
    bus_rd(A_CTL + 1, d);   chk("R8 cleared", d, 8'h10);

    // R10 RAM pass-through
    for (int k = 0; k < 32; k++) begin
      ram_a[k] = 11'($urandom_range(32'h7F7));
      d = 8'($urandom());
      ref_mem[ram_a[k]] = d;
      bus_wr(ram_a[k], d);
    end
    bus_wr(11'h7F7, 8'hA5);
    ref_mem[11'h7F7] = 8'hA5;
    chk("R10 no commit", commit, 0);
    for (int k = 0; k < 32; k++) begin
      bus_rd(ram_a[k], d);
      chk("R10 ram data", d, ref_mem[ram_a[k]]);
    end
    bus_rd(11'h7F7, d);     chk("R10 top ram byte", d, 8'hA5);
    bus_rd(A_CTL, d);       chk("R10 ctl untouched", d, 8'h00);
    bus_rd(A_CTL + 1, d);   chk("R10 sec untouched", d, 8'h10);
    chk("R10 osc untouched", osc_run, 1);

    finish_run();
  end
endmodule